// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 active-high, level-sensitive request lines and presents them to a processor as two interrupt outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source has an enable bit and a routing bit that sends it to one output or the other. A software request register can raise any source without the device being involved, which lets handler code be tested on its own. A protection bit can reject every register access made while the bus marks the requester as unprivileged. Nothing about a source is latched. Every status view follows the current input level.

Vectored dispatch uses 16 programmable slots. Each slot names one source and holds a handler address. A read of the vector register returns the handler address of the lowest-index enabled slot whose source is pending on the normal output. If no slot matches, the read returns a default address. A successful vector read claims that slot. A write of any value to the vector register ends service of the most recently claimed slot.

While a slot is in service, only slots with a smaller index can win a later vector read. A service tracker made of one in-service flag per slot enforces this. The tracker is a two-state machine. `SVC_IDLE` means no slot is in service. `SVC_ACTIVE` means at least one slot is in service. There are three transitions. *claim* takes `SVC_IDLE` to `SVC_ACTIVE` on a vector read that finds a match. *nest* keeps the machine in `SVC_ACTIVE` on a claim at higher priority, or on a completion that leaves a flag set. *retire* takes `SVC_ACTIVE` to `SVC_IDLE` on the completion that clears the last flag. A completion write in `SVC_IDLE` has no effect.

Top module: `vector_irq_ctrl`

## Requirements
- R1: After reset, all enables are 0 and all routing bits are 0 (normal output). All slot controls read 0, the default address reads 0, both outputs are low, and a vector read returns the default address.
- R2: The raw view at offset 0x08 equals `src_in` OR the software requests. It follows the input level on every read, with nothing held.
- R3: The routing register is at 0x0C, where bit=1 sends a source to the fast output. The status at 0x00 is raw AND enable AND NOT routing. The status at 0x04 is raw AND enable AND routing.
- R4: `irq_o` is the OR of the 0x00 status bits and `fiq_o` is the OR of the 0x04 status bits, both in the same cycle as the inputs.
- R5: Writing ones to 0x10 sets enable bits and writing ones to 0x14 clears them. Zero bits in either write leave enables unchanged. 0x10 reads back the enables.
- R6: Writing ones to 0x18 sets software requests and writing ones to 0x1C clears them. Zero bits leave them unchanged.
- R7: When bit 0 of 0x20 is 1, an access with `bus_user`=1 is rejected. Its write changes nothing, its read returns 0, and a rejected vector read claims no slot.
- R8: The slot control at 0x200+4y holds the source in bits 4:0 and the enable in bit 5, and reads back with the upper bits 0. The handler address at 0x100+4y and the default address at 0x34 read back as written.
- R9: A read of 0x30 returns the handler address of the lowest-index enabled slot whose source has its 0x00 status bit set. It returns the default address when no slot matches. A source that is masked or routed to the fast output never matches.
- R10: After slot y is claimed, later vector reads return the default address unless a slot with index below y matches, and such a slot preempts and is claimed.
- R11: A write to 0x30 ends the most recently claimed slot, so slots at lower priority than the restored level can be returned again. In the idle state the write has no effect.
- R12: Read data appears on `bus_rdata` one clock after the read request and is 0 after any cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Level-sensitive request lines, active high |
| bus_en | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_user | input | 1 | 1 = unprivileged requester |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The status and output paths are tried with several input patterns. The first mixes requests that are enabled and requests that are masked, which separates raw from masked status. The second moves one source to the fast output, which separates the two status views and the two outputs. The third drops an input, which shows that nothing is latched. Software requests are raised and cleared one bit at a time with no device input, so the set and clear registers are told apart from a plain overwrite.

Vector dispatch is driven by three sources bound to slots 0, 2 and 7. A second read while slot 2 is in service tells hold-off apart from plain priority selection. Raising the slot 0 source mid-service shows preemption. Completions out of a nested state show that the most recent claim ends first. Routing one source to the fast output and masking another shows that neither can be returned as a vector.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    // fixed register offsets (byte addresses)
    localparam logic [11:0] OFF_IRQ_STAT = 12'h000;
    localparam logic [11:0] OFF_FIQ_STAT = 12'h004;
    localparam logic [11:0] OFF_RAW      = 12'h008;
    localparam logic [11:0] OFF_ROUTE    = 12'h00C;
    localparam logic [11:0] OFF_EN_SET   = 12'h010;
    localparam logic [11:0] OFF_EN_CLR   = 12'h014;
    localparam logic [11:0] OFF_SW_SET   = 12'h018;
    localparam logic [11:0] OFF_SW_CLR   = 12'h01C;
    localparam logic [11:0] OFF_PROT     = 12'h020;
    localparam logic [11:0] OFF_VECT     = 12'h030;
    localparam logic [11:0] OFF_DEFAULT  = 12'h034;

    // upper address nibble selecting the per-slot regions
    localparam logic [3:0] REGION_SLOT_ADDR = 4'h1;
    localparam logic [3:0] REGION_SLOT_CTL  = 4'h2;

    typedef enum logic {
        SVC_IDLE   = 1'b0,
        SVC_ACTIVE = 1'b1
    } svc_state_t;

endpackage

// File: rtl/ivc_pick.sv
module ivc_pick #(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    localparam int unsigned SRCW  = $clog2(NSRC),
    localparam int unsigned SLOTW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]      slot_en,
    input  logic [NSLOT*SRCW-1:0] slot_src,
    input  logic [NSRC-1:0]       irq_stat,
    input  logic [SLOTW:0]        ceiling,
    output logic                  hit,
    output logic [SLOTW-1:0]      hit_idx
);

    logic [NSLOT-1:0] elig;

    // each slot is a candidate when enabled, its source pending on the
    // normal output, and its index above the current service level
    for (genvar g = 0; g < NSLOT; g++) begin : g_elig
        logic [SRCW-1:0] sel;
        assign sel     = slot_src[g*SRCW +: SRCW];
        assign elig[g] = slot_en[g] && irq_stat[sel] &&
                         ((SLOTW+1)'(g) < ceiling);
    end

    // lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit     = 1'b1;
                hit_idx = SLOTW'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_service.sv
module ivc_service
    import ivc_pkg::*;
#(
    parameter int unsigned NSLOT = 16,
    localparam int unsigned SLOTW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic [SLOTW-1:0] claim_idx,
    input  logic             done,
    output logic [SLOTW:0]   ceiling
);

    svc_state_t       st_q, st_d;
    logic [NSLOT-1:0] busy_q, busy_d;

    // in-service flags: a completion clears the lowest set flag (the most
    // recent claim, since claims only ever go to lower indices)
    always_comb begin
        busy_d = busy_q;
        if (done) begin
            busy_d = busy_q & (busy_q - NSLOT'(1));
        end
        if (claim) begin
            busy_d[claim_idx] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SVC_IDLE: begin
                if (claim) st_d = SVC_ACTIVE;          // claim
            end
            SVC_ACTIVE: begin
                if (busy_d == '0) st_d = SVC_IDLE;     // retire
            end                                        // else nest
            default: st_d = SVC_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SVC_IDLE;
            busy_q <= '0;
        end else begin
            st_q   <= st_d;
            busy_q <= busy_d;
        end
    end

    // output process: service level = index of lowest in-service slot
    always_comb begin
        ceiling = (SLOTW+1)'(NSLOT);
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (busy_q[i]) ceiling = (SLOTW+1)'(i);
        end
    end

    // R10: the picker only offers slots above the current service level
    a_r10_claim_above_level: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> ((SLOTW+1)'(claim_idx) < ceiling));

    // R10: a claim always leaves the tracker active
    a_r10_claim_goes_active: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> (st_q == SVC_ACTIVE));

    // R11: completion in idle changes nothing
    a_r11_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SVC_IDLE && done && !claim) |=> (st_q == SVC_IDLE && busy_q == '0));

    // R11: completion while active ends exactly one slot
    a_r11_done_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SVC_ACTIVE && done && !claim) |=>
            ($countones(busy_q) + 1 == $countones($past(busy_q))));

endmodule

// File: rtl/vector_irq_ctrl.sv
module vector_irq_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic            bus_user,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);

    localparam int unsigned SRCW  = $clog2(NSRC);
    localparam int unsigned SLOTW = $clog2(NSLOT);
    localparam int unsigned IDXW  = 6;

    // programmable state
    logic [NSRC-1:0]  en_r, route_r, soft_r;
    logic             prot_r;
    logic [DW-1:0]    def_addr_r;
    logic [DW-1:0]    slot_addr_r [NSLOT];
    logic [SRCW-1:0]  slot_src_r  [NSLOT];
    logic [NSLOT-1:0] slot_en_r;

    // derived status
    logic [NSRC-1:0] raw, irq_stat, fiq_stat;
    assign raw      = src_in | soft_r;
    assign irq_stat = raw & en_r & ~route_r;
    assign fiq_stat = raw & en_r & route_r;
    assign irq_o    = |irq_stat;
    assign fiq_o    = |fiq_stat;

    // access decode
    logic            acc, wr_acc, rd_acc;
    logic [IDXW-1:0] a_idx;
    logic            idx_ok;
    logic [SLOTW-1:0] sidx;
    logic            in_addr_rgn, in_ctl_rgn;

    assign acc         = bus_en && !(prot_r && bus_user);
    assign wr_acc      = acc && bus_we;
    assign rd_acc      = acc && !bus_we;
    assign a_idx       = bus_addr[IDXW+1:2];
    assign idx_ok      = (a_idx < IDXW'(NSLOT)) && (bus_addr[1:0] == 2'b00);
    assign sidx        = a_idx[SLOTW-1:0];
    assign in_addr_rgn = (bus_addr[AW-1:8] == REGION_SLOT_ADDR) && idx_ok;
    assign in_ctl_rgn  = (bus_addr[AW-1:8] == REGION_SLOT_CTL) && idx_ok;

    // priority pick and service tracking
    logic [NSLOT*SRCW-1:0] slot_src_flat;
    logic [SLOTW:0]        ceiling;
    logic                  hit;
    logic [SLOTW-1:0]      hit_idx;
    logic                  claim, done;

    for (genvar g = 0; g < NSLOT; g++) begin : g_flat
        assign slot_src_flat[g*SRCW +: SRCW] = slot_src_r[g];
    end

    ivc_pick #(.NSRC(NSRC), .NSLOT(NSLOT)) u_pick (
        .slot_en  (slot_en_r),
        .slot_src (slot_src_flat),
        .irq_stat (irq_stat),
        .ceiling  (ceiling),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    assign claim = rd_acc && (bus_addr == OFF_VECT) && hit;
    assign done  = wr_acc && (bus_addr == OFF_VECT);

    ivc_service #(.NSLOT(NSLOT)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (claim),
        .claim_idx (hit_idx),
        .done      (done),
        .ceiling   (ceiling)
    );

    // register writes
    logic [NSRC-1:0] wbits;
    assign wbits = bus_wdata[NSRC-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_r       <= '0;
            route_r    <= '0;
            soft_r     <= '0;
            prot_r     <= 1'b0;
            def_addr_r <= '0;
            slot_en_r  <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                slot_addr_r[i] <= '0;
                slot_src_r[i]  <= '0;
            end
        end else if (wr_acc) begin
            unique case (bus_addr)
                OFF_ROUTE:   route_r    <= wbits;
                OFF_EN_SET:  en_r       <= en_r | wbits;
                OFF_EN_CLR:  en_r       <= en_r & ~wbits;
                OFF_SW_SET:  soft_r     <= soft_r | wbits;
                OFF_SW_CLR:  soft_r     <= soft_r & ~wbits;
                OFF_PROT:    prot_r     <= bus_wdata[0];
                OFF_DEFAULT: def_addr_r <= bus_wdata;
                default: begin
                    if (in_addr_rgn) begin
                        slot_addr_r[sidx] <= bus_wdata;
                    end
                    if (in_ctl_rgn) begin
                        slot_src_r[sidx] <= bus_wdata[SRCW-1:0];
                        slot_en_r[sidx]  <= bus_wdata[5];
                    end
                end
            endcase
        end
    end

    // read mux
    logic [DW-1:0] rmux;
    always_comb begin
        rmux = '0;
        unique case (bus_addr)
            OFF_IRQ_STAT: rmux = DW'(irq_stat);
            OFF_FIQ_STAT: rmux = DW'(fiq_stat);
            OFF_RAW:      rmux = DW'(raw);
            OFF_ROUTE:    rmux = DW'(route_r);
            OFF_EN_SET:   rmux = DW'(en_r);
            OFF_SW_SET:   rmux = DW'(soft_r);
            OFF_PROT:     rmux = DW'(prot_r);
            OFF_VECT:     rmux = hit ? slot_addr_r[hit_idx] : def_addr_r;
            OFF_DEFAULT:  rmux = def_addr_r;
            default: begin
                if (in_addr_rgn) rmux = slot_addr_r[sidx];
                if (in_ctl_rgn)  rmux = DW'({slot_en_r[sidx], slot_src_r[sidx]});
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_acc ? rmux : '0;
    end

    // R5: enable clear takes effect on every bit written as one
    a_r5_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr == OFF_EN_CLR) |=> ((en_r & $past(wbits)) == '0));

    // R6: software set raises every bit written as one
    a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr == OFF_SW_SET) |=> ((soft_r & $past(wbits)) == $past(wbits)));

    // R7: a rejected write leaves the programmable state untouched
    a_r7_protected_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_user && prot_r) |=>
            ($stable(en_r) && $stable(route_r) && $stable(soft_r) && $stable(prot_r)));

    // R12: without an accepted read the data bus returns to zero
    a_r12_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> (bus_rdata == '0));

endmodule

// File: tb/sim_vector_irq_ctrl.sv
module sim_vector_irq_ctrl;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_user = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int ntot = 0;
    int nbad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vector_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_user(bus_user),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        ntot++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic usr = 1'b0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_user = usr;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_user = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic usr = 1'b0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_user = usr;
        @(negedge clk);
        bus_en = 1'b0; bus_user = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
        rd(12'h010, d); check("R1 enables", d, 32'h0);
        rd(12'h00C, d); check("R1 routing", d, 32'h0);
        rd(12'h208, d); check("R1 slot ctl", d, 32'h0);
        rd(12'h034, d); check("R1 default", d, 32'h0);
        rd(12'h030, d); check("R1 vector", d, 32'h0);
        @(negedge clk);
        check("R12 rdata idle", bus_rdata, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        src_in = 32'hA500_0011;
        rd(12'h008, d); check("R2 raw follows input", d, 32'hA500_0011);
        src_in = 32'h0000_0100;
        rd(12'h008, d); check("R2 raw not latched", d, 32'h0000_0100);
        check("R4 masked irq_o", {31'b0, irq_o}, 32'h0);
        src_in = '0;
    endtask

    task automatic t_enable_route();
        logic [31:0] d;
        src_in = 32'h0000_00F0;
        wr(12'h010, 32'h0000_0130);
        rd(12'h010, d); check("R5 enable set", d, 32'h0000_0130);
        rd(12'h000, d); check("R3 irq status", d, 32'h0000_0030);
        #1; check("R4 irq_o high", {31'b0, irq_o}, 32'h1);
        check("R4 fiq_o low", {31'b0, fiq_o}, 32'h0);
        wr(12'h00C, 32'h0000_0020);
        rd(12'h000, d); check("R3 irq after route", d, 32'h0000_0010);
        rd(12'h004, d); check("R3 fiq after route", d, 32'h0000_0020);
        wr(12'h014, 32'h0000_0010);
        #1; check("R4 irq_o low", {31'b0, irq_o}, 32'h0);
        check("R4 fiq_o high", {31'b0, fiq_o}, 32'h1);
        rd(12'h010, d); check("R5 enable clear", d, 32'h0000_0120);
        wr(12'h010, 32'h0);
        wr(12'h014, 32'h0);
        rd(12'h010, d); check("R5 zero writes no effect", d, 32'h0000_0120);
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h00C, 32'h0);
        src_in = '0;
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(12'h018, 32'h0000_8001);
        rd(12'h008, d); check("R6 soft set", d, 32'h0000_8001);
        wr(12'h018, 32'h0000_0002);
        rd(12'h008, d); check("R6 soft set keeps others", d, 32'h0000_8003);
        wr(12'h01C, 32'h0000_0001);
        rd(12'h008, d); check("R6 soft clear one", d, 32'h0000_8002);
        wr(12'h010, 32'h0000_0002);
        #1; check("R6 soft drives irq_o", {31'b0, irq_o}, 32'h1);
        wr(12'h01C, 32'hFFFF_FFFF);
        #1; check("R6 soft clear all", {31'b0, irq_o}, 32'h0);
        wr(12'h014, 32'hFFFF_FFFF);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        wr(12'h010, 32'h0000_0004);
        wr(12'h020, 32'h1);
        wr(12'h010, 32'hFFFF_0000, 1'b1);
        wr(12'h020, 32'h0, 1'b1);
        rd(12'h010, d); check("R7 user write rejected", d, 32'h0000_0004);
        src_in = 32'h0000_0004;
        rd(12'h008, d, 1'b1); check("R7 user read zero", d, 32'h0);
        rd(12'h008, d); check("R7 privileged read ok", d, 32'h0000_0004);
        wr(12'h020, 32'h0);
        wr(12'h010, 32'h0000_0040, 1'b1);
        rd(12'h010, d); check("R7 user write when unprotected", d, 32'h0000_0044);
        wr(12'h014, 32'hFFFF_FFFF);
        src_in = '0;
    endtask

    task automatic t_slots();
        logic [31:0] d;
        wr(12'h208, 32'hFFFF_FFE5);
        rd(12'h208, d); check("R8 slot ctl fields", d, 32'h0000_0025);
        wr(12'h23C, 32'hFFFF_FFFF);
        rd(12'h23C, d); check("R8 last slot ctl", d, 32'h0000_003F);
        wr(12'h104, 32'h1234_5678);
        rd(12'h104, d); check("R8 slot address", d, 32'h1234_5678);
        wr(12'h034, 32'hDEAD_0000);
        rd(12'h034, d); check("R8 default address", d, 32'hDEAD_0000);
        wr(12'h23C, 32'h0);
        wr(12'h208, 32'h0);
    endtask

    task automatic t_vector();
        logic [31:0] d;
        wr(12'h034, 32'hDEAD_0000);
        wr(12'h200, 32'h0000_0023); wr(12'h100, 32'h0000_00A0);  // slot0: src3
        wr(12'h208, 32'h0000_0025); wr(12'h108, 32'h0000_00A2);  // slot2: src5
        wr(12'h21C, 32'h0000_0029); wr(12'h11C, 32'h0000_00A7);  // slot7: src9
        wr(12'h010, 32'h0000_0228);
        wr(12'h00C, 32'h0);
        src_in = 32'h0000_0220;
        rd(12'h030, d, 1'b0); check("R9 highest priority", d, 32'h0000_00A2);
        rd(12'h030, d); check("R10 lower held off", d, 32'hDEAD_0000);
        src_in = 32'h0000_0228;
        rd(12'h030, d); check("R10 preempt", d, 32'h0000_00A0);
        rd(12'h030, d); check("R10 nested hold", d, 32'hDEAD_0000);
        src_in = 32'h0000_0220;
        wr(12'h030, 32'h0);
        rd(12'h030, d); check("R11 inner end keeps outer", d, 32'hDEAD_0000);
        wr(12'h030, 32'h0);
        rd(12'h030, d); check("R11 rearm", d, 32'h0000_00A2);
        wr(12'h030, 32'h0);
        wr(12'h030, 32'h0);
        wr(12'h00C, 32'h0000_0020);
        rd(12'h030, d); check("R9 fast-routed skipped", d, 32'h0000_00A7);
        wr(12'h030, 32'h0);
        wr(12'h014, 32'h0000_0200);
        rd(12'h030, d); check("R9 masked skipped", d, 32'hDEAD_0000);
        wr(12'h020, 32'h1);
        wr(12'h010, 32'h0000_0200);
        wr(12'h00C, 32'h0);
        rd(12'h030, d, 1'b1); check("R7 user vector read", d, 32'h0);
        rd(12'h030, d); check("R7 no claim on reject", d, 32'h0000_00A2);
        wr(12'h030, 32'h0);
        wr(12'h020, 32'h0);
        src_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw();
        t_enable_route();
        t_soft();
        t_protect();
        t_slots();
        t_vector();
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        ntot++;
        nbad++;
        $display("FAIL watchdog R12 got=running expected=finished");
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

endmodule